// File: doc/BRIEF.md
# Seven-Note Selectable Tone Player

The block plays one of seven tones, or a silent rest, for a fixed number of clock cycles each time a request arrives. It contains seven square-wave generators. Each generator has its own half-period input and runs from reset onward whether or not it is selected. A request carries a note number and uses a valid/ready handshake. Once a request is accepted, a multiplexer routes the chosen generator to the single `note` output for the programmed duration. When the duration ends, the output returns to low and the block is ready again.

Because the generators never stop, a note usually begins partway through a phase of its square wave. Note number 0 is a rest. A rest holds the block busy for the full duration but keeps the output low. The note number currently playing is driven on `note_sel` so that it can be shown on a display. With a clock slowed to about 48.8 kHz, a duration of 8192 cycles gives roughly a 167 ms note.

Top module: `note_player`

## Requirements
- R1: After synchronous active-high reset, `play_note_rdy` is 1, `note_sel` is 0 and `note` is 0.
- R2: A request is accepted on a clock edge where `play_note_val` and `play_note_rdy` are both 1. From the next cycle, `note_sel` equals the accepted `play_note_num` and `play_note_rdy` is 0.
- R3: After an accepted request with duration D ≥ 1, the block stays busy for exactly D cycles. After the D-th cycle, `play_note_rdy` is 1 and `note_sel` is 0.
- R4: A duration of 0 behaves like a duration of 1.
- R5: Requests presented while the block is busy are ignored. `note_sel` stays unchanged until the note ends.
- R6: While note k (1 to 7) plays, `note` equals the output of generator k. Generator k's half-period is taken from bits [16·k−1 : 16·(k−1)] of `note_periods`.
- R7: Each generator is low after reset and toggles every P+1 cycles, where P is its half-period input. Its full period is therefore 2·(P+1) cycles. It runs continuously, so its phase depends only on the cycles since reset and not on when it was selected.
- R8: Note number 0 is a rest. The block is busy for the full duration while `note` stays 0.
- R9: While the block is idle, `note` is 0.
- R10: The duration is captured when a request is accepted. Later changes to `note_duration` do not affect the note in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (slow tone clock) |
| rst | input | 1 | Synchronous active-high reset |
| note_duration | input | 16 | Note length in cycles, sampled at acceptance |
| note_periods | input | 112 | Seven 16-bit half-periods, note 1 in the low bits |
| play_note_val | input | 1 | Request valid |
| play_note_rdy | output | 1 | Ready for a request (idle) |
| play_note_num | input | 3 | Requested note number, 0 = rest |
| note_sel | output | 3 | Note currently playing, 0 when idle or resting |
| note | output | 1 | Square-wave output |

## Verification
The bench builds the block with its default parameters: seven notes and 16-bit periods and durations. It programs the half-periods with small random values from 0 to 9, so every generator toggles many times within notes only a few dozen cycles long. Several phase offsets and the half-period-0 case therefore show up in a short run. The bench draws durations from 0 to 20. This covers the zero and one-cycle cases, the back-to-back acceptance on the first ready cycle, and the ignoring of busy-time requests. The bench also changes the duration input mid-note.

// File: rtl/note_player.sv
module note_player #(
  parameter int NOTES = 7,
  parameter int PW    = 16,
  parameter int DW    = 16,
  localparam int NW   = $clog2(NOTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DW-1:0]       note_duration,
  input  logic [NOTES*PW-1:0] note_periods,
  input  logic                play_note_val,
  output logic                play_note_rdy,
  input  logic [NW-1:0]       play_note_num,
  output logic [NW-1:0]       note_sel,
  output logic                note
);

  logic [NOTES:0] taps;
  logic           busy;
  logic [DW-1:0]  remain;

  assign taps[0] = 1'b0;

  for (genvar g = 0; g < NOTES; g++) begin : gen_tone
    logic [PW-1:0] cnt;
    logic          wave;
    wire  [PW-1:0] half = note_periods[g*PW +: PW];

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt  <= '0;
        wave <= 1'b0;
      end else if (cnt >= half) begin
        cnt  <= '0;
        wave <= ~wave;
      end else begin
        cnt  <= cnt + 1'b1;
      end
    end

    assign taps[g+1] = wave;
  end

  assign play_note_rdy = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      remain   <= '0;
      note_sel <= '0;
    end else if (!busy) begin
      if (play_note_val) begin
        busy     <= 1'b1;
        remain   <= note_duration;
        note_sel <= play_note_num;
      end
    end else if (remain <= 1) begin
      busy     <= 1'b0;
      note_sel <= '0;
    end else begin
      remain <= remain - 1'b1;
    end
  end

  assign note = busy & taps[note_sel];

endmodule

module note_player_chk #(
  parameter int NW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          play_note_val,
  input logic          play_note_rdy,
  input logic [NW-1:0] play_note_num,
  input logic [NW-1:0] note_sel,
  input logic          note
);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (play_note_val && play_note_rdy) |=> (!play_note_rdy && note_sel == $past(play_note_num)));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!play_note_rdy) |=> (play_note_rdy || $stable(note_sel)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    play_note_rdy |-> (!note && note_sel == '0));

  // R8
  rest_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (note_sel == '0) |-> !note);

  // R3
  end_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(play_note_rdy) |-> (note_sel == '0));

endmodule

bind note_player note_player_chk #(.NW(NW)) i_note_player_chk (
  .clk(clk), .rst(rst), .play_note_val(play_note_val), .play_note_rdy(play_note_rdy),
  .play_note_num(play_note_num), .note_sel(note_sel), .note(note)
);

// File: tb/test_note_player.sv
module test_note_player;
  localparam int NOTES = 7;
  localparam int PW = 16;
  localparam int DW = 16;

  logic clk = 0;
  logic rst = 1;
  logic [DW-1:0] note_duration = '0;
  logic [NOTES*PW-1:0] note_periods = '0;
  logic play_note_val = 0;
  logic play_note_rdy;
  logic [2:0] play_note_num = '0;
  logic [2:0] note_sel;
  logic note;

  int checks = 0;
  int errors = 0;
  int ncyc = 0;
  int wd = 0;
  int per [1:NOTES];

  always #5 clk = ~clk;

  note_player i_note_player (
    .clk(clk), .rst(rst), .note_duration(note_duration), .note_periods(note_periods),
    .play_note_val(play_note_val), .play_note_rdy(play_note_rdy),
    .play_note_num(play_note_num), .note_sel(note_sel), .note(note)
  );

  always @(posedge clk) begin
    if (rst) ncyc <= 0;
    else ncyc <= ncyc + 1;
    wd <= wd + 1;
    if (wd > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic exp_wave(int k, int n);
    if (k == 0) return 1'b0;
    return 1'((n / (per[k] + 1)) % 2);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, ncyc);
    end
  endtask

  // Issue request on next edge; verify busy period, output, end state.
  task automatic play(int num, int dur, bit poke_busy, bit change_dur);
    int eff;
    eff = (dur == 0) ? 1 : dur;
    @(negedge clk);
    chk("R9 idle rdy before request", play_note_rdy, 1);
    chk("R9 idle note low", note, 0);
    play_note_val = 1;
    play_note_num = 3'(num);
    note_duration = DW'(dur);
    @(posedge clk);
    @(negedge clk);
    play_note_val = 0;
    for (int i = 0; i < eff; i++) begin
      chk("R2 busy after accept", play_note_rdy, 0);
      chk("R2 note_sel latched", note_sel, num);
      if (num == 0) chk("R8 rest silent", note, 0);
      else chk("R6 R7 note follows generator", note, exp_wave(num, ncyc));
      if (poke_busy && i == 0) begin
        play_note_val = 1;
        play_note_num = 3'((num + 3) % 8);
      end
      if (change_dur && i == 0) note_duration = DW'(dur + 40);
      @(negedge clk);
      if (poke_busy && i == 0) play_note_val = 0;
    end
    chk(dur == 0 ? "R4 zero duration ends after one cycle" : "R3 R10 ready after duration", play_note_rdy, 1);
    chk("R3 note_sel cleared", note_sel, 0);
    chk("R9 note low when idle", note, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 1; k <= NOTES; k++) begin
      per[k] = (k == 1) ? 0 : int'($urandom % 10);
      note_periods[(k-1)*PW +: PW] = PW'(per[k]);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset rdy", play_note_rdy, 1);
    chk("R1 reset note_sel", note_sel, 0);
    chk("R1 reset note", note, 0);
    rst = 0;

    play(3, 5, 0, 0);
    play(1, 7, 0, 0);
    play(0, 6, 0, 0);
    play(5, 0, 0, 0);
    play(2, 1, 0, 0);
    play(7, 9, 1, 0);
    play(4, 8, 0, 1);

    // R3 back-to-back: val held, re-accepted on first ready cycle
    @(negedge clk);
    play_note_val = 1; play_note_num = 3'd6; note_duration = 16'd3;
    @(posedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 ready cycle after first note", play_note_rdy, 1);
    play_note_num = 3'd2;
    @(posedge clk);
    @(negedge clk);
    play_note_val = 0;
    chk("R2 back-to-back accepted", note_sel, 2);
    chk("R6 R7 back-to-back generator", note, exp_wave(2, ncyc));
    repeat (3) @(negedge clk);
    chk("R3 back-to-back ends", play_note_rdy, 1);

    for (int t = 0; t < 60; t++) begin
      int n, d;
      n = int'($urandom % 8);
      d = int'($urandom % 21);
      play(n, d, ($urandom % 4) == 0, ($urandom % 5) == 0);
      repeat (int'($urandom % 4)) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule